// File: doc/BRIEF.md
# Timer with Selectable Trigger Output

This block is an up-counting time base. A prescaler divides the clock, and a counter steps through the range from zero to a reload limit. Each time the counter wraps, the block raises an update event. Software can also force an update event at any time. The block drives one trigger line for neighbouring blocks, and a 3-bit mode field picks what that line carries: the forced-update strobe, the run level, every update event, a channel-1 compare hit, or one of four compare-reference levels supplied from outside.

Software writes the registers over a plain one-cycle write port. A write is taken on every clock in which `wr_en` is high. There is no stall and no back-pressure. The read port is combinational and returns the live count and the register values. The reload register can be preloaded: when preload is on, a write lands in a shadow copy and reaches the active limit only at the next update event. The prescaler always works this way, so a new divide ratio applies from the next update event.

Register map (address: content). 0 is control: bit 0 run, bit 1 preload enable, bits 4:2 trigger mode, bit 7 force-update, which is a write-only strobe and reads 0. 1 is prescaler, 2 is reload (reads the written or shadow value), 3 is compare value. 4 (read-only) is the live count, 5 (read-only) is the active reload and 6 (read-only) is the active prescaler.

Top module: `trig_timer`

## Requirements
- R1: After reset, every address 0 to 6 reads zero and `trig_out` is low.
- R2: While run (control bit 0) is set, the count advances by one every prescaler+1 clocks. While run is clear, the count holds its value.
- R3: When the count equals the active reload (address 5) and is due to advance, it wraps to 0 and an update event occurs. A reload of 0 gives an update event on every count step.
- R4: With preload (control bit 1) clear, a write to address 2 changes the active reload at once. With preload set, the write changes only address 2, and address 5 takes the new value at the next update event.
- R5: A prescaler write (address 1) leaves the active prescaler (address 6) and the counting rate unchanged until the next update event.
- R6: Writing control with bit 7 set forces an update event. The count and the prescaler phase clear, and the active prescaler and reload load from addresses 1 and 2. Bit 7 reads back as 0.
- R7: In mode 2, `trig_out` is high for exactly the first clock in which the count shows the value written by each update event.
- R8: In mode 0, `trig_out` pulses for one clock only after a forced update; counter wraps do not raise it.
- R9: In mode 1, `trig_out` follows the run bit, delayed by one clock.
- R10: In mode 3, `trig_out` is high for one clock when the count takes a new value equal to the compare value (address 3).
- R11: In modes 4 to 7, `trig_out` follows `cmp_ref[mode-4]`, delayed by one clock; the other reference bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, taken every cycle it is high |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W (16) | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W (16) | Combinational read data |
| cmp_ref | input | 4 | Compare-reference levels for modes 4 to 7 |
| trig_out | output | 1 | Selected trigger output |

## Verification
A wrong prescaler phase or reload copy shows in the live count read within one period of prescaler+1 clocks, and it shifts every later wrap. A stale active reload appears at address 5 right after the write that should or should not have reached it. A wrong trigger selection shows on `trig_out` in the first clock after the causing event, because that output is registered exactly once. For that reason the bench samples the line cycle by cycle, not over a window.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [2:0] {
    TM_RESET  = 3'd0,
    TM_ENABLE = 3'd1,
    TM_UPDATE = 3'd2,
    TM_CMPHIT = 3'd3,
    TM_REF1   = 3'd4,
    TM_REF2   = 3'd5,
    TM_REF3   = 3'd6,
    TM_REF4   = 3'd7
  } trig_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned REF_N  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC     = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP     = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACT_ARR = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACT_PSC = 3'd6;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_PRE  = 1;
  localparam int unsigned CB_MODE = 2;
  localparam int unsigned CB_UG   = 7;
  localparam int unsigned CTRL_W  = 8;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              uev,
  output logic              run,
  output logic              preload,
  output trig_mode_e        mode,
  output logic              ug,
  output logic [PSC_W-1:0]  psc_reg,
  output logic [PSC_W-1:0]  psc_act,
  output logic [CNT_W-1:0]  arr_shadow,
  output logic [CNT_W-1:0]  arr_act,
  output logic [CNT_W-1:0]  cmp_val
);
  logic wr_ctrl, wr_psc, wr_arr, wr_cmp;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_psc  = wr_en && (wr_addr == A_PSC);
  assign wr_arr  = wr_en && (wr_addr == A_RELOAD);
  assign wr_cmp  = wr_en && (wr_addr == A_CMP);
  assign ug      = wr_ctrl && wr_data[CB_UG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      preload    <= 1'b0;
      mode       <= TM_RESET;
      psc_reg    <= '0;
      psc_act    <= '0;
      arr_shadow <= '0;
      arr_act    <= '0;
      cmp_val    <= '0;
    end else begin
      if (wr_ctrl) begin
        run     <= wr_data[CB_RUN];
        preload <= wr_data[CB_PRE];
        mode    <= trig_mode_e'(wr_data[CB_MODE +: 3]);
      end
      if (wr_psc) psc_reg <= wr_data[PSC_W-1:0];
      if (wr_cmp) cmp_val <= wr_data[CNT_W-1:0];
      if (uev) begin
        psc_act <= psc_reg;
        arr_act <= arr_shadow;
      end
      if (wr_arr) begin
        arr_shadow <= wr_data[CNT_W-1:0];
        if (!preload) arr_act <= wr_data[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tt_base.sv
module tt_base #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ug,
  input  logic [PSC_W-1:0] psc_act,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic [PSC_W-1:0] psc_cnt,
  output logic             ovf,
  output logic             cmp_hit
);
  logic             tick;
  logic [CNT_W-1:0] cnt_nxt;
  logic [PSC_W-1:0] psc_nxt;

  assign tick = run && (psc_cnt == psc_act);
  assign ovf  = tick && (cnt == arr_act);

  always_comb begin
    if (ug || ovf)     cnt_nxt = '0;
    else if (tick)     cnt_nxt = cnt + CNT_W'(1);
    else               cnt_nxt = cnt;
    if (ug || tick)    psc_nxt = '0;
    else if (run)      psc_nxt = psc_cnt + PSC_W'(1);
    else               psc_nxt = psc_cnt;
  end

  assign cmp_hit = (ug || tick) && (cnt_nxt == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      psc_cnt <= '0;
    end else begin
      cnt     <= cnt_nxt;
      psc_cnt <= psc_nxt;
    end
  end
endmodule

// File: rtl/tt_trig_sel.sv
module tt_trig_sel
  import tt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  trig_mode_e       mode,
  input  logic             ug,
  input  logic             uev,
  input  logic             run,
  input  logic             cmp_hit,
  input  logic [REF_N-1:0] cmp_ref,
  output logic             trig_out
);
  logic sel;

  always_comb begin
    case (mode)
      TM_RESET:  sel = ug;
      TM_ENABLE: sel = run;
      TM_UPDATE: sel = uev;
      TM_CMPHIT: sel = cmp_hit;
      default:   sel = cmp_ref[mode[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= sel;
  end
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  localparam int unsigned DATA_W = max3(CNT_W, PSC_W, CTRL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [REF_N-1:0]  cmp_ref,
  output logic              trig_out
);
  logic             run, preload, ug, uev, ovf, cmp_hit;
  trig_mode_e       mode;
  logic [PSC_W-1:0] psc_reg, psc_act, psc_cnt;
  logic [CNT_W-1:0] arr_shadow, arr_act, cmp_val, cnt;

  assign uev = ovf || ug;

  tt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .uev(uev), .run(run), .preload(preload), .mode(mode), .ug(ug),
    .psc_reg(psc_reg), .psc_act(psc_act), .arr_shadow(arr_shadow),
    .arr_act(arr_act), .cmp_val(cmp_val)
  );

  tt_base #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_base (
    .clk(clk), .rst_n(rst_n), .run(run), .ug(ug), .psc_act(psc_act),
    .arr_act(arr_act), .cmp_val(cmp_val), .cnt(cnt), .psc_cnt(psc_cnt),
    .ovf(ovf), .cmp_hit(cmp_hit)
  );

  tt_trig_sel u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ug(ug), .uev(uev), .run(run),
    .cmp_hit(cmp_hit), .cmp_ref(cmp_ref), .trig_out(trig_out)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CB_RUN]       = run;
        rd_data[CB_PRE]       = preload;
        rd_data[CB_MODE +: 3] = mode;
      end
      A_PSC:     rd_data[PSC_W-1:0] = psc_reg;
      A_RELOAD:  rd_data[CNT_W-1:0] = arr_shadow;
      A_CMP:     rd_data[CNT_W-1:0] = cmp_val;
      A_COUNT:   rd_data[CNT_W-1:0] = cnt;
      A_ACT_ARR: rd_data[CNT_W-1:0] = arr_act;
      A_ACT_PSC: rd_data[PSC_W-1:0] = psc_act;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             preload,
  input logic             ug,
  input trig_mode_e       mode,
  input logic [PSC_W-1:0] psc_cnt,
  input logic [PSC_W-1:0] psc_act,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_act,
  input logic             trig_out
);
  logic wrap_due;
  assign wrap_due = run && (psc_cnt == psc_act) && (cnt == arr_act);

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(cnt));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_due |=> (cnt == '0));

  p_preload_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !ug && !wrap_due) |=> $stable(arr_act));

  p_force_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0 && psc_cnt == '0));

  p_update_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_UPDATE && (ug || wrap_due)) |=> trig_out);

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_RESET && !ug) |=> !trig_out);

  p_enable_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TM_ENABLE) |=> (trig_out == $past(run)));
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .preload(preload), .ug(ug), .mode(mode),
  .psc_cnt(psc_cnt), .psc_act(psc_act), .cnt(cnt), .arr_act(arr_act),
  .trig_out(trig_out)
);

// File: tb/test_trig_timer.sv
module test_trig_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  cmp_ref = '0;
  logic        trig_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  trig_timer i_trig_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_ref(cmp_ref), .trig_out(trig_out)
  );

  always #10 clk = ~clk;

  // vector: {op 1=write 2=check, req, addr, wait cycles, value}
  localparam int NV = 25;
  localparam logic [31:0] VEC [NV] = '{
    {4'h1, 4'd5, 4'd1, 4'd0, 16'h0000},  // R5 prescaler 0
    {4'h1, 4'd4, 4'd2, 4'd0, 16'h0004},  // R4 reload 4, no preload
    {4'h1, 4'd6, 4'd0, 4'd0, 16'h0089},  // R6 run, mode 2, force update
    {4'h2, 4'd2, 4'd4, 4'd3, 16'h0003},  // R2
    {4'h2, 4'd4, 4'd5, 4'd0, 16'h0004},  // R4 immediate
    {4'h2, 4'd3, 4'd4, 4'd2, 16'h0000},  // R3 wrap
    {4'h2, 4'd2, 4'd4, 4'd3, 16'h0003},
    {4'h1, 4'd5, 4'd1, 4'd0, 16'h0001},  // R5 new prescaler
    {4'h2, 4'd5, 4'd6, 4'd0, 16'h0000},  // R5 not yet active
    {4'h2, 4'd5, 4'd4, 4'd0, 16'h0004},
    {4'h2, 4'd3, 4'd4, 4'd1, 16'h0000},  // R3
    {4'h2, 4'd5, 4'd6, 4'd0, 16'h0001},  // R5 active after update
    {4'h2, 4'd2, 4'd4, 4'd3, 16'h0001},  // R2 divide by 2
    {4'h2, 4'd2, 4'd4, 4'd3, 16'h0003},
    {4'h1, 4'd2, 4'd0, 4'd0, 16'h0008},  // R2 stop
    {4'h2, 4'd2, 4'd4, 4'd5, 16'h0003},  // R2 hold
    {4'h2, 4'd6, 4'd0, 4'd0, 16'h0008},  // R6 strobe reads 0
    {4'h1, 4'd4, 4'd0, 4'd0, 16'h000A},  // R4 preload on
    {4'h1, 4'd4, 4'd2, 4'd0, 16'h0009},
    {4'h2, 4'd4, 4'd5, 4'd0, 16'h0004},  // R4 active unchanged
    {4'h2, 4'd4, 4'd2, 4'd0, 16'h0009},  // R4 shadow
    {4'h1, 4'd6, 4'd0, 4'd0, 16'h008A},  // R6
    {4'h2, 4'd4, 4'd5, 4'd0, 16'h0009},  // R4 loaded at update
    {4'h2, 4'd6, 4'd4, 4'd0, 16'h0000},  // R6 count cleared
    {4'h2, 4'd6, 4'd6, 4'd0, 16'h0001}
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    rd_addr = a;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_trig(input logic exp, input string req, input int k);
    n_chk++;
    if (trig_out !== exp) begin
      n_bad++;
      $display("FAIL %s sample %0d: actual trig %b expected %b", req, k, trig_out, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    for (int a = 0; a < 7; a++) chk_rd(3'(a), 16'h0000, "R1");
    chk_trig(1'b0, "R1", 0);

    for (int i = 0; i < NV; i++) begin
      for (int w = 0; w < int'(VEC[i][19:16]); w++) cyc();
      if (VEC[i][31:28] == 4'h1) wr(VEC[i][22:20], VEC[i][15:0]);
      else chk_rd(VEC[i][22:20], VEC[i][15:0], $sformatf("R%0d vec %0d", VEC[i][27:24], i));
    end

    // R7 update pulses, reload 2
    do_reset();
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h0008);
    wr(3'd0, 16'h0089);
    for (int k = 0; k < 9; k++) begin
      chk_trig((k % 3) == 0, "R7", k);
      cyc();
    end
    // R3 boundary: reload 0 updates on every step
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h0089);
    for (int k = 0; k < 6; k++) begin
      chk_trig(1'b1, "R3", k);
      cyc();
    end
    // R8 reset mode: only forced update pulses
    wr(3'd0, 16'h0081);
    for (int k = 0; k < 7; k++) begin
      chk_trig(k == 0, "R8", k);
      cyc();
    end
    // R9 enable level, one cycle late
    wr(3'd0, 16'h0004);
    wr(3'd0, 16'h0005);
    chk_trig(1'b0, "R9", 0);
    cyc();
    chk_trig(1'b1, "R9", 1);
    wr(3'd0, 16'h0004);
    chk_trig(1'b1, "R9", 2);
    cyc();
    chk_trig(1'b0, "R9", 3);
    // R10 compare hit on entry to value 2, reload 4
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'h000C);
    wr(3'd0, 16'h008D);
    for (int k = 0; k < 10; k++) begin
      chk_trig((k == 2) || (k == 7), "R10", k);
      cyc();
    end
    // R11 reference levels
    wr(3'd0, 16'h0014);
    cmp_ref = 4'b1101;
    cyc(); cyc();
    chk_trig(1'b0, "R11 others ignored", 0);
    cmp_ref = 4'b0010;
    #1;
    chk_trig(1'b0, "R11", 1);
    cyc();
    chk_trig(1'b1, "R11", 2);
    wr(3'd0, 16'h001C);
    chk_trig(1'b1, "R11", 3);
    cyc();
    chk_trig(1'b0, "R11", 4);
    cmp_ref = 4'b1000;
    cyc();
    chk_trig(1'b1, "R11", 5);

    finish_run();
  end
endmodule